// File: doc/BRIEF.md
# Pad Ownership Control Bank

This block holds one control word per I/O pad and decides, pad by pad, who drives that pad. The management processor or the user project can own a pad. The block sits on a 32-bit Wishbone slave port. Software writes the low bit of a pad's word to choose the owner. The block then steers that pad's output value and its active-low output enable from the chosen side to the pad side.

The remaining bits of each word are kept as plain storage for electrical pad settings. They have no effect inside this block. There is one word per pad, in a fixed window. Pad n sits at byte offset 0x24 + 4·n from the window base. Every access finishes with a single-cycle acknowledge and is never stalled. The pad-side buses are plain level signals with no handshake, because a pad always takes the current value.

Top module: `gpio_own_bank`

## Requirements
- R1: There are 38 pad words. Pad n is at address 0x26000000 + 0x24 + 4·n, so pad 0 is at 0x26000024 and pad 37 is at 0x260000B8. Word address bits [1:0] are ignored.
- R2: After reset, every pad word reads 0x00000001. Bit 0 is the owner bit and is set to 1 (management owns the pad). All other bits are 0.
- R3: A request is wb_cyc and wb_stb both high while wb_ack is low. The block answers each request with wb_ack high for exactly one cycle, on the clock edge after the request is presented. wb_ack never rises without a request.
- R4: When a pad's bit 0 is 1, pad_out and pad_oeb for that pad follow mgmt_out and mgmt_oeb. When bit 0 is 0, they follow user_out and user_oeb. A new owner takes effect from the clock edge that acknowledges the write.
- R5: Writes honour the byte selects. wb_sel[0] updates bits 7:0 and wb_sel[1] updates bits 12:8. Bits whose byte lane is not selected keep their value.
- R6: Only bits 12:0 of a pad word are stored. Bits 31:13 always read 0, and writes to them are dropped.
- R7: An address outside the pad range reads as 0 and a write to it changes no pad word. This covers offsets 0x00–0x23 and 0xBC–0xFF inside the window, and any address outside the window 0x26000000–0x260000FF. Such accesses are still acknowledged.
- R8: While rst is high, every bit of pad_oeb is 1 (output disabled), whatever the four pad-side input buses carry.
- R9: wb_dat_r is 0 in the cycle a write is acknowledged. It carries the addressed word in the cycle a read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_sel | input | 4 | Byte lane selects |
| wb_adr | input | 32 | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_ack | output | 1 | One-cycle transfer acknowledge |
| wb_dat_r | output | 32 | Read data, valid with wb_ack |
| mgmt_out | input | 38 | Management-side pad output values |
| mgmt_oeb | input | 38 | Management-side output enables, active low |
| user_out | input | 38 | User-side pad output values |
| user_oeb | input | 38 | User-side output enables, active low |
| pad_out | output | 38 | Steered pad output values |
| pad_oeb | output | 38 | Steered pad output enables, active low |

## Verification
The hardest case to reach from the ports is a partial write that changes some bits of a word and keeps others. This must happen on the two edge pads of the range while the owner bit both flips and holds. The stimulus writes pad 37 through one byte lane at a time, reads back the merged word, and checks the steered outputs after each write. It then hits the addresses just below 0x24 and just above 0xB8, and an address outside the window. Reading the neighbouring pads afterwards shows that none of those writes reached storage.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
  localparam int          NUM_PADS_D  = 38;
  localparam int          CFG_W_D     = 13;
  localparam logic [31:0] WIN_BASE_D  = 32'h2600_0000;
  localparam int          WIN_BITS_D  = 8;
  localparam logic [7:0]  FIRST_OFF_D = 8'h24;
  localparam int          OWNER_BIT   = 0;
endpackage

// File: rtl/gpio_own_decode.sv
module gpio_own_decode #(
  parameter int          NUM_PADS  = gpio_own_pkg::NUM_PADS_D,
  parameter int          WIN_BITS  = gpio_own_pkg::WIN_BITS_D,
  parameter logic [31:0] WIN_BASE  = gpio_own_pkg::WIN_BASE_D,
  parameter logic [7:0]  FIRST_OFF = gpio_own_pkg::FIRST_OFF_D,
  parameter int          IDX_W     = $clog2(NUM_PADS)
) (
  input  logic [31:0]      adr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int WW = WIN_BITS - 2;
  localparam logic [WW-1:0] FIRST_WORD = WW'(FIRST_OFF >> 2);
  localparam logic [WW-1:0] PAD_COUNT  = WW'(NUM_PADS);

  logic          in_win;
  logic [WW-1:0] word;
  logic [WW-1:0] rel;

  always_comb begin
    in_win = (adr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
    word   = adr[WIN_BITS-1:2];
    rel    = word - FIRST_WORD;
    hit    = in_win && (word >= FIRST_WORD) && (rel < PAD_COUNT);
    idx    = IDX_W'(rel);
  end
endmodule

// File: rtl/gpio_own_regfile.sv
module gpio_own_regfile #(
  parameter int NUM_PADS = gpio_own_pkg::NUM_PADS_D,
  parameter int CFG_W    = gpio_own_pkg::CFG_W_D,
  parameter int IDX_W    = $clog2(NUM_PADS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [3:0]                         wr_sel,
  input  logic [31:0]                        wr_data,
  output logic [NUM_PADS-1:0][CFG_W-1:0]     cfg
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic pick;
    assign pick = wr_en && (wr_idx == IDX_W'(p));
    for (genvar b = 0; b < CFG_W; b++) begin : g_bit
      localparam logic RST_V = (b == gpio_own_pkg::OWNER_BIT);
      always_ff @(posedge clk) begin
        if (rst)
          cfg[p][b] <= RST_V;
        else if (pick && wr_sel[b/8])
          cfg[p][b] <= wr_data[b];
      end
    end
  end
endmodule

// File: rtl/gpio_own_steer.sv
module gpio_own_steer #(
  parameter int NUM_PADS = gpio_own_pkg::NUM_PADS_D
) (
  input  logic                hold_off,
  input  logic [NUM_PADS-1:0] own_mgmt,
  input  logic [NUM_PADS-1:0] mgmt_out,
  input  logic [NUM_PADS-1:0] mgmt_oeb,
  input  logic [NUM_PADS-1:0] user_out,
  input  logic [NUM_PADS-1:0] user_oeb,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oeb
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign pad_out[p] = own_mgmt[p] ? mgmt_out[p] : user_out[p];
    assign pad_oeb[p] = hold_off | (own_mgmt[p] ? mgmt_oeb[p] : user_oeb[p]);
  end
endmodule

// File: rtl/gpio_own_bank.sv
module gpio_own_bank #(
  parameter int NUM_PADS = gpio_own_pkg::NUM_PADS_D,
  parameter int CFG_W    = gpio_own_pkg::CFG_W_D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc,
  input  logic                wb_stb,
  input  logic                wb_we,
  input  logic [3:0]          wb_sel,
  input  logic [31:0]         wb_adr,
  input  logic [31:0]         wb_dat_w,
  output logic                wb_ack,
  output logic [31:0]         wb_dat_r,
  input  logic [NUM_PADS-1:0] mgmt_out,
  input  logic [NUM_PADS-1:0] mgmt_oeb,
  input  logic [NUM_PADS-1:0] user_out,
  input  logic [NUM_PADS-1:0] user_oeb,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oeb
);
  localparam int IDX_W = $clog2(NUM_PADS);

  logic                           dec_hit;
  logic [IDX_W-1:0]               dec_idx;
  logic                           fire;
  logic                           wr_en;
  logic [NUM_PADS-1:0][CFG_W-1:0] cfg;
  logic [NUM_PADS-1:0]            own_mgmt;
  logic [31:0]                    rd_word;

  gpio_own_decode #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W)) u_dec (
    .adr(wb_adr), .hit(dec_hit), .idx(dec_idx)
  );

  assign fire  = wb_cyc && wb_stb && !wb_ack;
  assign wr_en = fire && wb_we && dec_hit;

  gpio_own_regfile #(.NUM_PADS(NUM_PADS), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(dec_idx),
    .wr_sel(wb_sel), .wr_data(wb_dat_w), .cfg(cfg)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_own
    assign own_mgmt[p] = cfg[p][gpio_own_pkg::OWNER_BIT];
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) rd_word[CFG_W-1:0] = cfg[dec_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_dat_r <= '0;
    end else begin
      wb_ack   <= fire;
      wb_dat_r <= (fire && !wb_we) ? rd_word : 32'h0;
    end
  end

  gpio_own_steer #(.NUM_PADS(NUM_PADS)) u_steer (
    .hold_off(rst), .own_mgmt(own_mgmt),
    .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb),
    .user_out(user_out), .user_oeb(user_oeb),
    .pad_out(pad_out), .pad_oeb(pad_oeb)
  );
endmodule

// File: rtl/gpio_own_chk.sv
module gpio_own_chk #(
  parameter int NUM_PADS = gpio_own_pkg::NUM_PADS_D,
  parameter int IDX_W    = $clog2(NUM_PADS)
) (
  input logic                clk,
  input logic                rst,
  input logic                wb_cyc,
  input logic                wb_stb,
  input logic                wb_we,
  input logic [3:0]          wb_sel,
  input logic [31:0]         wb_dat_w,
  input logic                wb_ack,
  input logic [31:0]         wb_dat_r,
  input logic [NUM_PADS-1:0] pad_oeb,
  input logic [NUM_PADS-1:0] own_mgmt,
  input logic                dec_hit,
  input logic [IDX_W-1:0]    dec_idx
);
  logic req;
  assign req = wb_cyc && wb_stb && !wb_ack;

  a_r3_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> wb_ack);
  a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);
  a_r3_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc && wb_stb) |=> !wb_ack);
  a_r4_owner_written: assert property (@(posedge clk) disable iff (rst)
    (req && wb_we && dec_hit && wb_sel[0]) |=> (own_mgmt[$past(dec_idx)] == $past(wb_dat_w[0])));
  a_r7_miss_write_inert: assert property (@(posedge clk) disable iff (rst)
    (req && wb_we && !dec_hit) |=> $stable(own_mgmt));
  a_r7_miss_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req && !wb_we && !dec_hit) |=> (wb_dat_r == 32'h0));
  a_r9_write_ack_zero: assert property (@(posedge clk) disable iff (rst)
    (req && wb_we) |=> (wb_dat_r == 32'h0));

  always @(posedge clk) begin
    if (rst) a_r8_oeb_held: assert (&pad_oeb);
  end
endmodule

bind gpio_own_bank gpio_own_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_ack(wb_ack), .wb_dat_r(wb_dat_r),
  .pad_oeb(pad_oeb), .own_mgmt(own_mgmt), .dec_hit(dec_hit), .dec_idx(dec_idx)
);

// File: tb/gpio_own_bank_bench.sv
`timescale 1ns/1ps
module gpio_own_bank_bench;
  localparam int NP = 38;
  localparam int CW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [3:0]    wb_sel = 4'h0;
  logic [31:0]   wb_adr = '0, wb_dat_w = '0;
  logic          wb_ack;
  logic [31:0]   wb_dat_r;
  logic [NP-1:0] mgmt_out = '0, mgmt_oeb = '0, user_out = '0, user_oeb = '0;
  logic [NP-1:0] pad_out, pad_oeb;

  int errors = 0;
  int checks = 0;
  logic [CW-1:0] model [NP];
  logic [31:0]   expq [$];

  always #2 clk = ~clk;

  gpio_own_bank u_gpio_own_bank (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_sel(wb_sel), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_ack(wb_ack),
    .wb_dat_r(wb_dat_r), .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb),
    .user_out(user_out), .user_oeb(user_oeb), .pad_out(pad_out), .pad_oeb(pad_oeb)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pad_addr(input int n);
    return 32'h2600_0024 + 32'(4 * n);
  endfunction

  // monitor: every acknowledge pops one expected data word (R9 writes, R1/R2/R5/R6/R7 reads)
  always @(negedge clk) begin
    if (!rst && wb_ack) begin
      if (expq.size() == 0) check(1'b0, "R3 stray ack", 64'(wb_ack), 64'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(wb_dat_r == e, "R9/R1 ack data", 64'(wb_dat_r), 64'(e));
      end
    end
  end

  task automatic xfer(input bit we, input logic [31:0] adr, input logic [31:0] dat, input logic [3:0] sel);
    int idx;
    bit hit;
    hit = (adr[31:8] == 24'h260000) && (adr[7:0] >= 8'h24) && (adr[7:0] <= 8'hBB);
    idx = hit ? int'((adr[7:0] - 8'h24) >> 2) : 0;
    if (we) begin
      if (hit)
        for (int b = 0; b < CW; b++) if (sel[b/8]) model[idx][b] = dat[b];
      expq.push_back(32'h0);
    end else begin
      expq.push_back(hit ? 32'(model[idx]) : 32'h0);
    end
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
    @(negedge clk);
    check(wb_ack == 1'b1, "R3 ack after request", 64'(wb_ack), 64'h1);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    @(negedge clk);
    check(wb_ack == 1'b0, "R3 ack one cycle", 64'(wb_ack), 64'h0);
  endtask

  task automatic check_pads(input string tag);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      eo[p] = model[p][0] ? mgmt_out[p] : user_out[p];
      ee[p] = model[p][0] ? mgmt_oeb[p] : user_oeb[p];
    end
    check(pad_out == eo, {"R4 pad_out ", tag}, 64'(pad_out), 64'(eo));
    check(pad_oeb == ee, {"R4 pad_oeb ", tag}, 64'(pad_oeb), 64'(ee));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) model[p] = 13'h0001;
    // R8: outputs disabled while reset is held, even with both sides enabling
    repeat (3) @(negedge clk);
    check(&pad_oeb, "R8 oeb held in reset", 64'(pad_oeb), {26'h0, {NP{1'b1}}});
    check(wb_ack == 1'b0, "R3 no ack in reset", 64'(wb_ack), 64'h0);
    mgmt_out = 38'h2A_5555_AAAA; mgmt_oeb = 38'h0F_0000_FFFF;
    user_out = ~mgmt_out;        user_oeb = 38'h30_FFFF_0000;
    @(negedge clk);
    check(&pad_oeb, "R8 oeb held with new inputs", 64'(pad_oeb), {26'h0, {NP{1'b1}}});
    rst = 0;
    @(negedge clk);
    // R2: reset value, all pads on management side
    check_pads("after reset");
    xfer(0, pad_addr(0), 0, 4'hF);
    xfer(0, pad_addr(37), 0, 4'hF);
    xfer(0, pad_addr(19), 0, 4'hF);
    // R4 + R1: hand pad 5 and pad 37 to user
    xfer(1, pad_addr(5), 32'h0, 4'h1);
    check_pads("pad5 user");
    xfer(1, 32'h2600_00B8, 32'h0, 4'h1);
    check_pads("pad37 user");
    check(pad_out[37] == user_out[37], "R1 pad37 address", 64'(pad_out[37]), 64'(user_out[37]));
    // R5: lane 1 only leaves owner bit (lane 0) alone
    xfer(1, pad_addr(37), 32'hFFFF_FF01, 4'h2);
    xfer(0, pad_addr(37), 0, 4'hF);
    check_pads("R5 lane1");
    // R5: lane 0 only flips owner back, keeps bits 12:8
    xfer(1, pad_addr(37), 32'h0000_00A5, 4'h1);
    xfer(0, pad_addr(37), 0, 4'hF);
    check_pads("R5 lane0");
    // R5: no lanes selected -> nothing changes
    xfer(1, pad_addr(37), 32'h0, 4'h0);
    xfer(0, pad_addr(37), 0, 4'hF);
    // R6: upper bits not stored
    xfer(1, pad_addr(10), 32'hFFFF_FFFF, 4'hF);
    xfer(0, pad_addr(10), 0, 4'hF);
    // R7: holes in the window and outside the window
    xfer(1, 32'h2600_0020, 32'h0, 4'hF);
    xfer(1, 32'h2600_00BC, 32'h0, 4'hF);
    xfer(1, 32'h2700_0024, 32'h0, 4'hF);
    xfer(0, 32'h2600_0020, 0, 4'hF);
    xfer(0, 32'h2600_00BC, 0, 4'hF);
    xfer(0, 32'h2700_0024, 0, 4'hF);
    xfer(0, pad_addr(0), 0, 4'hF);
    xfer(0, pad_addr(37), 0, 4'hF);
    check_pads("R7 after misses");
    // R4: change pad-side patterns with a mixed ownership map
    for (int p = 0; p < NP; p += 3) xfer(1, pad_addr(p), 32'h0, 4'h1);
    mgmt_out = 38'h15_AAAA_5555; user_out = 38'h3F_0F0F_F0F0;
    mgmt_oeb = 38'h00_FFFF_0000; user_oeb = 38'h3F_0000_FFFF;
    @(negedge clk);
    check_pads("mixed map");
    for (int p = 0; p < NP; p++) xfer(0, pad_addr(p), 0, 4'hF);
    while (expq.size() != 0) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule